// File: doc/BRIEF.md
# Banked Memory Configuration Unit

This block holds the eleven byte-wide configuration registers of a small memory manager for an 8-bit processor with two 64K RAM banks. The processor reads and writes them through a synchronous register port: chip-select, write-enable, a 4-bit index and an 8-bit data bus. The unit turns the register contents into registered control outputs for the address decoder around it:
- whether the I/O window is visible;
- which ROM groups are visible;
- which RAM bank is active;
- the video RAM base;
- the low and high shared-RAM limits;
- the 17-bit physical bases of relocated page zero and page one.

A second port stands at a fixed high address window of five bytes. Its offset 0 reads and loads the configuration register directly. Offsets 1 to 4 load the configuration register from one of four preset registers and ignore the data byte.

Address decoding of the processor map and the memories themselves live outside this block. The decoder compares addresses against the limits and bases driven here.

Top module: `bank_cfg_unit`

## Requirements
- R1: A port write to index 0 updates the outputs at the clock edge that stores it. `io_vis` is the inverse of bit 0. `basic_lo_vis` is the inverse of bit 1. `basic_hi_vis` is 1 when bits 3:2 are both 0. `kern_vis`, `char_vis` and `edit_vis` are 1 when bits 5:4 are both 0. `ram_bank` equals bit 6.
- R2: After reset the outputs are as follows. `io_vis`, `basic_lo_vis`, `basic_hi_vis`, `kern_vis` and `edit_vis` are 1. `char_vis` and `ram_bank` are 0. `vid_base` is 0, `shr_lo_lim` is 0x0000 and `shr_hi_lim` is 0xFFFF. `pz_base` is 0x00000 and `po_base` is 0x00100. All eleven registers read as stored zero.
- R3: A write to index 6 sets the shared size from bits 1:0: code 0 gives 0x0400, 1 gives 0x1000, 2 gives 0x2000 and 3 gives 0x4000. If bit 2 is set, `shr_lo_lim` is the size; otherwise it is 0. If bit 3 is set, `shr_hi_lim` is 0xFFFF minus the size; otherwise it is 0xFFFF.
- R4: A write to index 6 sets `vid_base` to bits 7:6 of the written byte placed at address bits 9:8.
- R5: Writes to indices 7 to 10 recompute both page bases. `pz_base` is bit 0 of index 8 placed at bit 16, plus index 7 times 256. `po_base` is formed the same way from indices 10 and 9. No other write changes either base.
- R6: `rdata` shows the register selected by `idx` combinationally. Index 5 reads with bit 7 forced to 1. Indices 11 to 15 read 0x0F.
- R7: A write to index 5 stores the byte with bit 7 cleared and bits 5:4 set.
- R8: `mir_rdata` always shows the configuration register. A mirror write at offset 0 loads the configuration register with `mir_wdata`, and the outputs follow as in R1 at the same edge.
- R9: A mirror write at offsets 1 to 4 loads the configuration register from the register with that index, ignoring `mir_wdata`. A mirror write at offsets 5 to 7 has no effect.
- R10: When a port write to index 0 and a mirror write land in the same cycle, the port write decides the configuration register.
- R11: Port writes to indices 11 to 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Register port select |
| we | input | 1 | Register port write enable |
| idx | input | 4 | Register index |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `idx` |
| mir_cs | input | 1 | Mirror port select |
| mir_we | input | 1 | Mirror port write enable |
| mir_sel | input | 3 | Mirror offset (0 direct, 1 to 4 preset) |
| mir_wdata | input | 8 | Mirror write data |
| mir_rdata | output | 8 | Configuration register value |
| io_vis | output | 1 | I/O window visible |
| basic_lo_vis | output | 1 | Low interpreter ROM visible |
| basic_hi_vis | output | 1 | High interpreter ROM visible |
| kern_vis | output | 1 | Kernel ROM visible |
| char_vis | output | 1 | Character ROM visible |
| edit_vis | output | 1 | Editor ROM visible |
| ram_bank | output | 1 | Active RAM bank |
| vid_base | output | 17 | Video RAM physical base |
| shr_lo_lim | output | 16 | Addresses below this are shared |
| shr_hi_lim | output | 16 | Addresses above this are shared |
| pz_base | output | 17 | Page-zero physical base |
| po_base | output | 17 | Page-one physical base |

## Verification
A wrong stored register shows on `rdata` as soon as its index is selected, in the same cycle and with no edge in between. A wrong configuration byte also shows on `mir_rdata` at once. A wrong decoded flag, limit or base is registered, so it appears one edge after the write that caused it. It then stays visible until the next write of the same register, so checking every output after every cycle catches it on the first cycle it exists. A page base that moves after a write to an unrelated index, or a preset load that takes the data byte instead of the preset, is caught the cycle after that mirror or port write.

// File: rtl/bank_cfg_pkg.sv
// Shared widths, register indices and the decoded visibility record
// of the banked memory configuration unit. Assumes an 8-bit data path.
package bank_cfg_pkg;
    localparam int DW       = 8;
    localparam int AW       = 16;
    localparam int PAW      = 17;
    localparam int IW       = 4;
    localparam int NREG     = 11;
    localparam int SELW     = 3;
    localparam int NPRESET  = 4;
    localparam int IDX_CFG  = 0;
    localparam int IDX_MODE = 5;
    localparam int IDX_RCR  = 6;
    localparam int IDX_PZL  = 7;
    localparam int IDX_PZH  = 8;
    localparam int IDX_POL  = 9;
    localparam int IDX_POH  = 10;
    localparam logic [DW-1:0] HOLE_VAL = 8'h0F;

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        logic io;
        logic blo;
        logic bhi;
        logic kern;
        logic chr;
        logic edit;
        logic bank;
    } vis_t;
endpackage

// File: rtl/bank_cfg_regs.sv
// Register file with processor port and fixed mirror port.
// Computes next register contents and load strobes for the decoders.
// Assumes index 0 is the configuration register and the mirror offsets
// 1..NPRESET name preset registers at the same indices.
module bank_cfg_regs
    import bank_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            we,
    input  logic [IW-1:0]   idx,
    input  byte_t           wdata,
    input  logic            mir_cs,
    input  logic            mir_we,
    input  logic [SELW-1:0] mir_sel,
    input  byte_t           mir_wdata,
    output byte_t           rdata,
    output byte_t           mir_rdata,
    output byte_t           cfg_nxt,
    output byte_t           rcr_nxt,
    output logic [1:0][DW-1:0] pg_lo_nxt,
    output logic [1:0][DW-1:0] pg_hi_nxt,
    output logic            ld_cfg,
    output logic            ld_rcr,
    output logic            ld_page
);
    byte_t regs_q [NREG];
    byte_t regs_d [NREG];
    logic  port_hit;
    logic  mir_hit;
    byte_t mir_val;

    // Decide which writes land this cycle.
    always_comb begin
        port_hit = cs && we && (int'(idx) < NREG);
        mir_hit  = mir_cs && mir_we && (int'(mir_sel) <= NPRESET);
        mir_val  = (mir_sel == '0) ? mir_wdata : regs_q[int'(mir_sel)];
    end

    // Build next register contents; port write overrides mirror on index 0.
    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (mir_hit) regs_d[IDX_CFG] = mir_val;
        if (port_hit) begin
            if (int'(idx) == IDX_MODE)
                regs_d[int'(idx)] = (wdata & 8'h7F) | 8'h30;
            else
                regs_d[int'(idx)] = wdata;
        end
    end

    // Register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    // Load strobes for the registered decoders.
    always_comb begin
        ld_cfg  = mir_hit || (port_hit && int'(idx) == IDX_CFG);
        ld_rcr  = port_hit && int'(idx) == IDX_RCR;
        ld_page = port_hit && int'(idx) >= IDX_PZL && int'(idx) <= IDX_POH;
    end

    // Next values handed to the decoders.
    always_comb begin
        cfg_nxt      = regs_d[IDX_CFG];
        rcr_nxt      = regs_d[IDX_RCR];
        pg_lo_nxt[0] = regs_d[IDX_PZL];
        pg_hi_nxt[0] = regs_d[IDX_PZH];
        pg_lo_nxt[1] = regs_d[IDX_POL];
        pg_hi_nxt[1] = regs_d[IDX_POH];
    end

    // Read multiplexers for both ports.
    always_comb begin
        if (int'(idx) >= NREG)          rdata = HOLE_VAL;
        else if (int'(idx) == IDX_MODE) rdata = regs_q[IDX_MODE] | 8'h80;
        else                            rdata = regs_q[int'(idx)];
        mir_rdata = regs_q[IDX_CFG];
    end
endmodule

// File: rtl/bank_cfg_decode.sv
// Decodes the configuration byte into visibility flags and bank select.
// Registered; loads on ld. Character ROM starts hidden although the
// reset byte would decode it visible, so the flags carry their own reset.
module bank_cfg_decode
    import bank_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld,
    input  byte_t cfg,
    output vis_t  vis
);
    vis_t dec;

    // Combinational field decode of the configuration byte.
    always_comb begin
        dec.io   = ~cfg[0];
        dec.blo  = ~cfg[1];
        dec.bhi  = (cfg[3:2] == 2'b00);
        dec.kern = (cfg[5:4] == 2'b00);
        dec.chr  = (cfg[5:4] == 2'b00);
        dec.edit = (cfg[5:4] == 2'b00);
        dec.bank = cfg[6];
    end

    // Hold decoded flags; reload when the configuration byte is written.
    always_ff @(posedge clk) begin
        if (!rst_n)  vis <= '{io:1'b1, blo:1'b1, bhi:1'b1, kern:1'b1,
                               chr:1'b0, edit:1'b1, bank:1'b0};
        else if (ld) vis <= dec;
    end
endmodule

// File: rtl/bank_cfg_share.sv
// Decodes the RAM configuration byte into video base and shared limits.
// Registered; loads on ld. Sizes: code 0 = 1K, else 2K shifted by code.
module bank_cfg_share
    import bank_cfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld,
    input  byte_t          rcr,
    output logic [PAW-1:0] vid_base,
    output logic [AW-1:0]  lo_lim,
    output logic [AW-1:0]  hi_lim
);
    localparam logic [AW-1:0] TOP      = '1;
    localparam logic [AW-1:0] MIN_SIZE = AW'(16'h0400);
    localparam logic [AW-1:0] STEP     = AW'(16'h0800);

    logic [AW-1:0] size;

    // Window size from the two size bits.
    always_comb begin
        if (rcr[1:0] == 2'b00) size = MIN_SIZE;
        else                   size = STEP << rcr[1:0];
    end

    // Hold limits and video base; reload on a write of the RAM config byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_base <= '0;
            lo_lim   <= '0;
            hi_lim   <= TOP;
        end else if (ld) begin
            vid_base <= PAW'({rcr[7:6], 8'h00});
            lo_lim   <= rcr[2] ? size : '0;
            hi_lim   <= rcr[3] ? (TOP - size) : TOP;
        end
    end
endmodule

// File: rtl/bank_cfg_pages.sv
// Relocation bases for the NPAGE low pages, one registered base each.
// Base = high byte bit 0 as bank bit, low byte as page number.
module bank_cfg_pages
    import bank_cfg_pkg::*;
#(
    parameter int NPAGE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld,
    input  logic [NPAGE-1:0][DW-1:0]   pg_lo,
    input  logic [NPAGE-1:0][DW-1:0]   pg_hi,
    output logic [NPAGE-1:0][PAW-1:0]  base
);
    for (genvar p = 0; p < NPAGE; p++) begin : g_page
        // Hold one page base; reset to its identity location.
        always_ff @(posedge clk) begin
            if (!rst_n)  base[p] <= PAW'(p * 256);
            else if (ld) base[p] <= {pg_hi[p][0], pg_lo[p], 8'h00};
        end
    end
endmodule

// File: rtl/bank_cfg_unit.sv
// Top of the banked memory configuration unit: register file plus three
// registered decoders. Assumes single clock, synchronous active-low reset.
module bank_cfg_unit
    import bank_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            we,
    input  logic [3:0]      idx,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic            mir_cs,
    input  logic            mir_we,
    input  logic [2:0]      mir_sel,
    input  logic [7:0]      mir_wdata,
    output logic [7:0]      mir_rdata,
    output logic            io_vis,
    output logic            basic_lo_vis,
    output logic            basic_hi_vis,
    output logic            kern_vis,
    output logic            char_vis,
    output logic            edit_vis,
    output logic            ram_bank,
    output logic [16:0]     vid_base,
    output logic [15:0]     shr_lo_lim,
    output logic [15:0]     shr_hi_lim,
    output logic [16:0]     pz_base,
    output logic [16:0]     po_base
);
    byte_t                     cfg_nxt;
    byte_t                     rcr_nxt;
    logic [1:0][DW-1:0]        pg_lo_nxt;
    logic [1:0][DW-1:0]        pg_hi_nxt;
    logic                      ld_cfg;
    logic                      ld_rcr;
    logic                      ld_page;
    vis_t                      vis;
    logic [1:0][PAW-1:0]       bases;

    bank_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .idx(idx), .wdata(wdata),
        .mir_cs(mir_cs), .mir_we(mir_we), .mir_sel(mir_sel),
        .mir_wdata(mir_wdata), .rdata(rdata), .mir_rdata(mir_rdata),
        .cfg_nxt(cfg_nxt), .rcr_nxt(rcr_nxt), .pg_lo_nxt(pg_lo_nxt),
        .pg_hi_nxt(pg_hi_nxt), .ld_cfg(ld_cfg), .ld_rcr(ld_rcr),
        .ld_page(ld_page)
    );

    bank_cfg_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ld(ld_cfg), .cfg(cfg_nxt), .vis(vis)
    );

    bank_cfg_share u_share (
        .clk(clk), .rst_n(rst_n), .ld(ld_rcr), .rcr(rcr_nxt),
        .vid_base(vid_base), .lo_lim(shr_lo_lim), .hi_lim(shr_hi_lim)
    );

    bank_cfg_pages #(.NPAGE(2)) u_pages (
        .clk(clk), .rst_n(rst_n), .ld(ld_page), .pg_lo(pg_lo_nxt),
        .pg_hi(pg_hi_nxt), .base(bases)
    );

    // Fan the packed records out to the ports.
    always_comb begin
        io_vis       = vis.io;
        basic_lo_vis = vis.blo;
        basic_hi_vis = vis.bhi;
        kern_vis     = vis.kern;
        char_vis     = vis.chr;
        edit_vis     = vis.edit;
        ram_bank     = vis.bank;
        pz_base      = bases[0];
        po_base      = bases[1];
    end
endmodule

// File: rtl/bank_cfg_chk.sv
// Port-level properties of the configuration unit, bound to its top.
module bank_cfg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs,
    input logic        we,
    input logic [3:0]  idx,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic        mir_cs,
    input logic        mir_we,
    input logic [2:0]  mir_sel,
    input logic [7:0]  mir_wdata,
    input logic        io_vis,
    input logic        ram_bank,
    input logic [15:0] shr_lo_lim,
    input logic [15:0] shr_hi_lim,
    input logic [16:0] pz_base,
    input logic [16:0] po_base
);
    logic port_cfg_wr;
    logic port_page_wr;
    always_comb begin
        port_cfg_wr  = cs && we && idx == 4'd0;
        port_page_wr = cs && we && idx >= 4'd7 && idx <= 4'd10;
    end

    AST_BANK_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        port_cfg_wr |=> ram_bank == $past(wdata[6])); // R1
    AST_IO_FROM_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_cs && mir_we && mir_sel == 3'd0 && !port_cfg_wr)
        |=> io_vis == !$past(mir_wdata[0])); // R8
    AST_HOLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        idx >= 4'd11 |-> rdata == 8'h0F); // R6
    AST_MODE_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        idx == 4'd5 |-> rdata[7]); // R6
    AST_SHARE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        shr_lo_lim <= 16'h4000 && shr_hi_lim >= 16'hBFFF); // R3
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !port_page_wr |=> $stable(pz_base) && $stable(po_base)); // R5
endmodule

bind bank_cfg_unit bank_cfg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .idx(idx), .wdata(wdata),
    .rdata(rdata), .mir_cs(mir_cs), .mir_we(mir_we), .mir_sel(mir_sel),
    .mir_wdata(mir_wdata), .io_vis(io_vis), .ram_bank(ram_bank),
    .shr_lo_lim(shr_lo_lim), .shr_hi_lim(shr_hi_lim),
    .pz_base(pz_base), .po_base(po_base)
);

// File: tb/bank_cfg_unit_tb_top.sv
module bank_cfg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 0, we = 0, mir_cs = 0, mir_we = 0;
    logic [3:0]  idx = 0;
    logic [2:0]  mir_sel = 0;
    logic [7:0]  wdata = 0, mir_wdata = 0;
    logic [7:0]  rdata, mir_rdata;
    logic        io_vis, basic_lo_vis, basic_hi_vis, kern_vis, char_vis, edit_vis, ram_bank;
    logic [16:0] vid_base, pz_base, po_base;
    logic [15:0] shr_lo_lim, shr_hi_lim;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state.
    logic [7:0]  em [11];
    logic        e_io, e_blo, e_bhi, e_kern, e_chr, e_edit, e_bank;
    logic [16:0] e_vid, e_pz, e_po;
    logic [15:0] e_lo, e_hi;

    always #5 clk = ~clk;

    bank_cfg_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .idx(idx), .wdata(wdata),
        .rdata(rdata), .mir_cs(mir_cs), .mir_we(mir_we), .mir_sel(mir_sel),
        .mir_wdata(mir_wdata), .mir_rdata(mir_rdata), .io_vis(io_vis),
        .basic_lo_vis(basic_lo_vis), .basic_hi_vis(basic_hi_vis),
        .kern_vis(kern_vis), .char_vis(char_vis), .edit_vis(edit_vis),
        .ram_bank(ram_bank), .vid_base(vid_base), .shr_lo_lim(shr_lo_lim),
        .shr_hi_lim(shr_hi_lim), .pz_base(pz_base), .po_base(po_base)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] share_size(input logic [1:0] code);
        case (code)
            2'd0: return 16'h0400;
            2'd1: return 16'h1000;
            2'd2: return 16'h2000;
            default: return 16'h4000;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] i);
        if (i >= 4'd11) return 8'h0F;
        if (i == 4'd5)  return em[5] | 8'h80;
        return em[int'(i)];
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 11; k++) em[k] = 8'h00;
        e_io = 1; e_blo = 1; e_bhi = 1; e_kern = 1; e_chr = 0; e_edit = 1; e_bank = 0;
        e_vid = 0; e_lo = 16'h0000; e_hi = 16'hFFFF; e_pz = 17'h00000; e_po = 17'h00100;
    endtask

    task automatic check_outs();
        chk("R1 io_vis", 32'(io_vis), 32'(e_io));
        chk("R1 basic_lo_vis", 32'(basic_lo_vis), 32'(e_blo));
        chk("R1 basic_hi_vis", 32'(basic_hi_vis), 32'(e_bhi));
        chk("R1 kern_vis", 32'(kern_vis), 32'(e_kern));
        chk("R1 char_vis", 32'(char_vis), 32'(e_chr));
        chk("R1 edit_vis", 32'(edit_vis), 32'(e_edit));
        chk("R1 ram_bank", 32'(ram_bank), 32'(e_bank));
        chk("R4 vid_base", 32'(vid_base), 32'(e_vid));
        chk("R3 shr_lo_lim", 32'(shr_lo_lim), 32'(e_lo));
        chk("R3 shr_hi_lim", 32'(shr_hi_lim), 32'(e_hi));
        chk("R5 pz_base", 32'(pz_base), 32'(e_pz));
        chk("R5 po_base", 32'(po_base), 32'(e_po));
    endtask

    // One bus cycle: drive after falling edge, check reads, then outputs after rise.
    task automatic step(input logic c, input logic w, input logic [3:0] i, input logic [7:0] d,
                        input logic mc, input logic mw, input logic [2:0] ms, input logic [7:0] md);
        logic [7:0] n [11];
        logic port, mhit;
        logic [7:0] mval;
        @(negedge clk);
        cs = c; we = w; idx = i; wdata = d;
        mir_cs = mc; mir_we = mw; mir_sel = ms; mir_wdata = md;
        #2;
        chk("R6 rdata", 32'(rdata), 32'(exp_read(i)));
        chk("R8 mir_rdata", 32'(mir_rdata), 32'(em[0]));
        for (int k = 0; k < 11; k++) n[k] = em[k];
        port = c && w && (i < 4'd11);
        mhit = mc && mw && (ms <= 3'd4);
        mval = (ms == 3'd0) ? md : em[int'(ms) % 11];
        if (mhit) n[0] = mval;                            // R8 R9
        if (port) n[int'(i)] = (i == 4'd5) ? ((d & 8'h7F) | 8'h30) : d; // R7 R10
        @(posedge clk);
        #1;
        for (int k = 0; k < 11; k++) em[k] = n[k];
        if (mhit || (port && i == 4'd0)) begin
            e_io = ~n[0][0]; e_blo = ~n[0][1]; e_bhi = (n[0][3:2] == 0);
            e_kern = (n[0][5:4] == 0); e_chr = e_kern; e_edit = e_kern; e_bank = n[0][6];
        end
        if (port && i == 4'd6) begin
            e_vid = {7'b0, n[6][7:6], 8'h00};
            e_lo  = n[6][2] ? share_size(n[6][1:0]) : 16'h0000;
            e_hi  = n[6][3] ? (16'hFFFF - share_size(n[6][1:0])) : 16'hFFFF;
        end
        if (port && i >= 4'd7 && i <= 4'd10) begin
            e_pz = {n[8][0], n[7], 8'h00};
            e_po = {n[10][0], n[9], 8'h00};
        end
        check_outs();
    endtask

    task automatic pw(input logic [3:0] i, input logic [7:0] d);
        step(1, 1, i, d, 0, 0, 3'd0, 8'h00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2;
        check_outs();                                   // R2 reset state
        for (int k = 0; k < 16; k++) step(1, 0, 4'(k), 8'h00, 0, 0, 3'd0, 8'h00); // R2 R6

        pw(4'd0, 8'h7F);                                // R1 everything hidden, bank 1
        pw(4'd0, 8'h00);                                // R1 everything visible
        pw(4'd0, 8'h44);                                // R1 high interpreter hidden
        for (int c = 0; c < 4; c++) begin
            pw(4'd6, 8'(8'hCC | c));                    // R3 R4 both windows
            pw(4'd6, 8'(8'h44 | c));                    // R3 low only
            pw(4'd6, 8'(8'h88 | c));                    // R3 high only
        end
        pw(4'd6, 8'h03);                                // R3 sharing off
        pw(4'd7, 8'h12); pw(4'd8, 8'hFF);               // R5
        pw(4'd9, 8'hAB); pw(4'd10, 8'h01);              // R5
        pw(4'd3, 8'h55);                                // R5 base holds on unrelated write
        pw(4'd5, 8'hFF); step(1, 0, 4'd5, 0, 0, 0, 0, 0); // R7
        pw(4'd5, 8'h00); step(1, 0, 4'd5, 0, 0, 0, 0, 0); // R7
        step(0, 0, 4'd0, 0, 1, 1, 3'd0, 8'h3E);          // R8 direct mirror load
        pw(4'd1, 8'h01); pw(4'd2, 8'h0E); pw(4'd4, 8'h40);
        for (int s = 1; s <= 4; s++) step(0, 0, 4'd0, 0, 1, 1, 3'(s), 8'hFF); // R9
        for (int s = 5; s <= 7; s++) step(0, 0, 4'd0, 0, 1, 1, 3'(s), 8'h3F); // R9 no effect
        step(1, 1, 4'd0, 8'h02, 1, 1, 3'd0, 8'h7F);      // R10 port wins
        step(1, 1, 4'd0, 8'h41, 1, 1, 3'd2, 8'h00);      // R10 port wins over preset
        for (int k = 11; k < 16; k++) pw(4'(k), 8'hA5);  // R11
        for (int k = 0; k < 11; k++) step(1, 0, 4'(k), 0, 0, 0, 0, 0); // R11 readback

        for (int n = 0; n < 3000; n++) begin
            logic mc;
            mc = ($urandom % 4) == 0;
            step(($urandom % 8) != 0, $urandom % 2, 4'($urandom), 8'($urandom),
                 mc, $urandom % 2, 3'($urandom), 8'($urandom));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule